// File: doc/BRIEF.md
# Watermarked Audio Channel FIFO

This block is the data buffer of one audio transfer channel. It stores up to 512 words of 32 bits. It can run in capture direction, where an audio source pushes samples and software or a DMA engine drains them. It can also run in playback direction, where software or DMA fills the buffer and an audio sink pops samples. The direction decides which threshold drives the channel's event output. That output can serve as an interrupt or as a DMA request line.

Both thresholds live in one packed control word. The low threshold (almost-empty) sits in bits 24:16 and the high threshold (almost-full) in bits 8:0. A separate status word exposes the raw read and write indices. Software can then work out the free space (playback) or the filled space (capture) without a counter register. Real-full and real-empty flags resolve the case the indices alone cannot: equal indices mean either nothing stored or everything stored. A single-cycle flush strobe empties the buffer. Software issues it before the channel enters interrupt or DMA mode, and again when it leaves DMA mode.

Top module: `audio_wm_fifo`

## Requirements
- R1: After reset the buffer is empty. `realEmpty`=1, `realFull`=0 and `ptrStatus`=0. `wmWord` reads 0x000001FF, meaning high threshold 511 and low threshold 0.
- R2: Words leave in the order they entered, and up to 512 words are held. `popData` always shows the oldest stored word. `realFull` is 1 exactly when 512 words are held, and `realEmpty` is 1 exactly when none are.
- R3: A push while `realFull`=1 (with no pop) is ignored. Neither index nor the stored contents change.
- R4: A pop while `realEmpty`=1 is ignored and both indices keep their values.
- R5: A `flushReq` pulse empties the buffer on the next clock edge and returns both indices to zero. It takes precedence over a push or pop in the same cycle.
- R6: A write with `wmWrEn`=1 loads the low threshold from `wmWrData[24:16]` and the high threshold from `wmWrData[8:0]`. `wmWord` returns those two fields in the same positions, and all other bits read zero. Without a write, `wmWord` holds its value.
- R7: `ptrStatus[25:16]` holds the read index and `ptrStatus[9:0]` holds the write index, each as a 9-bit slot number with bit 9 zero. All other bits read zero. With W the write index and R the read index:
  - Filled space is W-R when W≥R, and 512-R+W otherwise.
  - Free space is 512 minus the filled space.
- R8: `almostFull` is 1 while the number of stored words is at or above the high threshold.
- R9: `almostEmpty` is 1 while the number of stored words is at or below the low threshold.
- R10: `thrEvent` follows `almostFull` when `dirCapture`=1 (capture) and follows `almostEmpty` when `dirCapture`=0 (playback).
- R11: A push and a pop in the same cycle both take effect when the buffer is neither full nor empty. When full, only the pop takes effect. When empty, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirCapture | input | 1 | 1: capture direction, 0: playback direction |
| pushValid | input | 1 | Push `pushData` this cycle |
| pushData | input | 32 | Word to store |
| popReq | input | 1 | Remove the oldest word this cycle |
| popData | output | 32 | Oldest stored word |
| flushReq | input | 1 | Single-cycle strobe that empties the buffer |
| wmWrEn | input | 1 | Load the threshold word |
| wmWrData | input | 32 | New threshold word |
| wmWord | output | 32 | Current threshold word |
| ptrStatus | output | 32 | Read index in 25:16, write index in 9:0 |
| realFull | output | 1 | 512 words held |
| realEmpty | output | 1 | No words held |
| almostFull | output | 1 | Fill level at or above high threshold |
| almostEmpty | output | 1 | Fill level at or below low threshold |
| thrEvent | output | 1 | Direction-selected threshold event |

## Verification
The bound checker watches several properties on every cycle:
- the full and empty flags are never both set;
- blocked pushes and pops leave the index word untouched;
- a flush always produces an empty buffer with zero indices;
- the threshold word only changes on a write;
- a full buffer in capture mode, or an empty buffer in playback mode, always raises the event.

Other behaviours need the directed scenarios, which compare against a reference queue:
- word ordering across the index wrap;
- the exact fill levels where each threshold flag switches;
- the field packing of the threshold and index words;
- the free and filled space arithmetic when the write index is below the read index.

// File: rtl/awf_pkg.sv
`timescale 1ns/1ps
package awf_pkg;
  // register word layout
  localparam int REG_W    = 32;
  localparam int LOW_LSB  = 16;  // low (almost-empty) threshold field
  localparam int HIGH_LSB = 0;   // high (almost-full) threshold field
  localparam int IDX_F_W  = 10;  // width of each index field in the status word
  localparam int RD_LSB   = 16;
  localparam int WR_LSB   = 0;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } awfStrobe_t;
endpackage

// File: rtl/awf_datapath.sv
`timescale 1ns/1ps
module awf_datapath
  import awf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  awfStrobe_t        strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic [ADDR_W-1:0] wrIdx,
  output logic [ADDR_W-1:0] rdIdx,
  output logic [ADDR_W:0]   level
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr[ADDR_W-1:0]] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  // the wrap bit makes the difference exact from 0 to DEPTH
  assign level   = wrPtr - rdPtr;
  assign wrIdx   = wrPtr[ADDR_W-1:0];
  assign rdIdx   = rdPtr[ADDR_W-1:0];
  assign popData = store[rdIdx];
endmodule

// File: rtl/awf_ctrl.sv
`timescale 1ns/1ps
module awf_ctrl
  import awf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirCapture,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             flushReq,
  input  logic             wmWrEn,
  input  logic [REG_W-1:0] wmWrData,
  input  logic [ADDR_W:0]  level,
  output awfStrobe_t       strobe,
  output logic [REG_W-1:0] wmWord,
  output logic             realFull,
  output logic             realEmpty,
  output logic             almostFull,
  output logic             almostEmpty,
  output logic             thrEvent
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] HIGH_RST = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] LOW_RST  = '0;

  logic [ADDR_W-1:0] highThr, lowThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highThr <= HIGH_RST;
      lowThr  <= LOW_RST;
    end else if (wmWrEn) begin
      highThr <= wmWrData[HIGH_LSB +: ADDR_W];
      lowThr  <= wmWrData[LOW_LSB +: ADDR_W];
    end
  end

  always_comb begin
    wmWord = '0;
    wmWord[HIGH_LSB +: ADDR_W] = highThr;
    wmWord[LOW_LSB +: ADDR_W]  = lowThr;
  end

  assign realFull  = (level == PTR_W'(DEPTH));
  assign realEmpty = (level == '0);

  assign almostFull  = (level >= {1'b0, highThr});
  assign almostEmpty = (level <= {1'b0, lowThr});
  assign thrEvent    = dirCapture ? almostFull : almostEmpty;

  // flush wins; a blocked side never moves its pointer
  always_comb begin
    strobe.flush = flushReq;
    strobe.push  = pushValid && !realFull  && !flushReq;
    strobe.pop   = popReq    && !realEmpty && !flushReq;
  end
endmodule

// File: rtl/audio_wm_fifo.sv
`timescale 1ns/1ps
module audio_wm_fifo
  import awf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirCapture,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic              flushReq,
  input  logic              wmWrEn,
  input  logic [REG_W-1:0]  wmWrData,
  output logic [REG_W-1:0]  wmWord,
  output logic [REG_W-1:0]  ptrStatus,
  output logic              realFull,
  output logic              realEmpty,
  output logic              almostFull,
  output logic              almostEmpty,
  output logic              thrEvent
);
  awfStrobe_t        strobe;
  logic [ADDR_W-1:0] wrIdx, rdIdx;
  logic [ADDR_W:0]   level;

  awf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirCapture(dirCapture),
    .pushValid(pushValid), .popReq(popReq), .flushReq(flushReq),
    .wmWrEn(wmWrEn), .wmWrData(wmWrData), .level(level),
    .strobe(strobe), .wmWord(wmWord),
    .realFull(realFull), .realEmpty(realEmpty),
    .almostFull(almostFull), .almostEmpty(almostEmpty), .thrEvent(thrEvent)
  );

  awf_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .popData(popData), .wrIdx(wrIdx), .rdIdx(rdIdx), .level(level)
  );

  always_comb begin
    ptrStatus = '0;
    ptrStatus[RD_LSB +: IDX_F_W] = IDX_F_W'(rdIdx);
    ptrStatus[WR_LSB +: IDX_F_W] = IDX_F_W'(wrIdx);
  end
endmodule

// File: rtl/audio_wm_fifo_chk.sv
`timescale 1ns/1ps
module audio_wm_fifo_chk
  import awf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             dirCapture,
  input logic             pushValid,
  input logic             popReq,
  input logic             flushReq,
  input logic             wmWrEn,
  input logic [REG_W-1:0] wmWord,
  input logic [REG_W-1:0] ptrStatus,
  input logic             realFull,
  input logic             realEmpty,
  input logic             thrEvent
);
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(realFull && realEmpty));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    realFull && pushValid && !popReq && !flushReq |=> $stable(ptrStatus));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    realEmpty && popReq && !pushValid && !flushReq |=> $stable(ptrStatus));

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> realEmpty && (ptrStatus == '0));

  a_r6_wm_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wmWrEn |=> $stable(wmWord));

  a_r10_capture_event: assert property (@(posedge clk) disable iff (!rstN)
    dirCapture && realFull |-> thrEvent);

  a_r10_playback_event: assert property (@(posedge clk) disable iff (!rstN)
    !dirCapture && realEmpty |-> thrEvent);
endmodule

bind audio_wm_fifo audio_wm_fifo_chk u_chk (
  .clk(clk), .rstN(rstN), .dirCapture(dirCapture),
  .pushValid(pushValid), .popReq(popReq), .flushReq(flushReq),
  .wmWrEn(wmWrEn), .wmWord(wmWord), .ptrStatus(ptrStatus),
  .realFull(realFull), .realEmpty(realEmpty), .thrEvent(thrEvent)
);

// File: tb/audio_wm_fifo_tb.sv
`timescale 1ns/1ps
module audio_wm_fifo_tb;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dirCapture = 1'b1;
  logic        pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic        popReq = 1'b0;
  logic [31:0] popData;
  logic        flushReq = 1'b0;
  logic        wmWrEn = 1'b0;
  logic [31:0] wmWrData = '0;
  logic [31:0] wmWord, ptrStatus;
  logic        realFull, realEmpty, almostFull, almostEmpty, thrEvent;

  int checks = 0;
  int fails  = 0;
  logic [31:0] q[$];
  int wIdx = 0;
  int rIdx = 0;

  always #5 clk = ~clk;

  audio_wm_fifo u_dut (
    .clk(clk), .rstN(rstN), .dirCapture(dirCapture),
    .pushValid(pushValid), .pushData(pushData), .popReq(popReq),
    .popData(popData), .flushReq(flushReq),
    .wmWrEn(wmWrEn), .wmWrData(wmWrData), .wmWord(wmWord),
    .ptrStatus(ptrStatus), .realFull(realFull), .realEmpty(realEmpty),
    .almostFull(almostFull), .almostEmpty(almostEmpty), .thrEvent(thrEvent)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one clock of stimulus; the reference queue follows the requirements
  task automatic cyc(input logic push, input logic [31:0] d, input logic pop, input logic flush);
    int sz;
    logic dp, du;
    @(negedge clk);
    pushValid = push; pushData = d; popReq = pop; flushReq = flush;
    sz = q.size();
    du = pop && (sz > 0) && !flush;
    dp = push && (sz < DEPTH) && !flush;
    if (du) chk("R2 oldest word on popData", popData, q[0]);
    @(posedge clk);
    #1;
    pushValid = 1'b0; popReq = 1'b0; flushReq = 1'b0;
    if (flush) begin
      q.delete(); wIdx = 0; rIdx = 0;
    end else begin
      if (du) begin void'(q.pop_front()); rIdx = (rIdx + 1) % DEPTH; end
      if (dp) begin q.push_back(d); wIdx = (wIdx + 1) % DEPTH; end
    end
  endtask

  task automatic checkState(input string req);
    chk({req, " realEmpty"}, 32'(realEmpty), 32'(q.size() == 0));
    chk({req, " realFull"},  32'(realFull),  32'(q.size() == DEPTH));
    chk({req, " ptrStatus"}, ptrStatus, (32'(rIdx) << 16) | 32'(wIdx));
  endtask

  task automatic writeWm(input logic [31:0] v);
    @(negedge clk);
    wmWrEn = 1'b1; wmWrData = v;
    @(posedge clk);
    #1 wmWrEn = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 realEmpty", 32'(realEmpty), 32'd1);
    chk("R1 realFull", 32'(realFull), 32'd0);
    chk("R1 ptrStatus", ptrStatus, 32'h0);
    chk("R1 wmWord", wmWord, 32'h0000_01FF);
  endtask

  task automatic t_wm_packing();
    writeWm(32'h1234_5678);
    chk("R6 wmWord fields", wmWord, 32'h0034_0078);
    repeat (2) cyc(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R6 wmWord held", wmWord, 32'h0034_0078);
  endtask

  task automatic t_thresholds();
    writeWm((32'd2 << 16) | 32'd4);
    dirCapture = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      cyc(1'b1, 32'h5000_0000 + 32'(k), 1'b0, 1'b0);
      chk("R8 almostFull", 32'(almostFull), 32'(k >= 4));
      chk("R9 almostEmpty", 32'(almostEmpty), 32'(k <= 2));
      chk("R10 capture event", 32'(thrEvent), 32'(k >= 4));
    end
    @(negedge clk) dirCapture = 1'b0;
    #1 chk("R10 playback event at level 5", 32'(thrEvent), 32'd0);
    for (int k = 4; k >= 2; k--) cyc(1'b0, 32'h0, 1'b1, 1'b0);
    chk("R10 playback event at level 2", 32'(thrEvent), 32'd1);
    cyc(1'b0, 32'h0, 1'b0, 1'b1);
    dirCapture = 1'b1;
    checkState("R5 after flush");
  endtask

  task automatic t_flush_priority();
    for (int k = 0; k < 3; k++) cyc(1'b1, 32'h6000_0000 + 32'(k), 1'b0, 1'b0);
    cyc(1'b1, 32'h6666_6666, 1'b1, 1'b1);
    checkState("R5 flush beats push/pop");
    chk("R5 ptrStatus zero", ptrStatus, 32'h0);
  endtask

  task automatic t_simultaneous();
    cyc(1'b1, 32'h7000_0001, 1'b1, 1'b0);
    checkState("R11 empty push+pop");
    cyc(1'b1, 32'h7000_0002, 1'b0, 1'b0);
    cyc(1'b1, 32'h7000_0003, 1'b1, 1'b0);
    checkState("R11 both sides move");
    while (q.size() > 0) cyc(1'b0, 32'h0, 1'b1, 1'b0);
    checkState("R11 drained");
  endtask

  task automatic t_wrap_and_limits();
    cyc(1'b0, 32'h0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) cyc(1'b1, 32'h8000_0000 + 32'(k), 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 32'h0, 1'b1, 1'b0);
    checkState("R7 W above R");
    chk("R7 filled W-R", 32'(ptrStatus[9:0]) - 32'(ptrStatus[25:16]), 32'(q.size()));
    for (int k = 0; k < 510; k++) cyc(1'b1, 32'h9000_0000 + 32'(k), 1'b0, 1'b0);
    checkState("R2 full at 512");
    cyc(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
    checkState("R3 push on full ignored");
    cyc(1'b1, 32'hBEEF_0001, 1'b1, 1'b0);
    checkState("R11 full push+pop pops only");
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    checkState("R7 W below R");
    chk("R7 free R-W", 32'(ptrStatus[25:16]) - 32'(ptrStatus[9:0]), 32'(DEPTH - q.size()));
    chk("R7 filled 512-R+W", 32'(DEPTH) - 32'(ptrStatus[25:16]) + 32'(ptrStatus[9:0]),
        32'(q.size()));
    while (q.size() > 0) cyc(1'b0, 32'h0, 1'b1, 1'b0);
    checkState("R2 drained in order");
    cyc(1'b0, 32'h0, 1'b1, 1'b0);
    checkState("R4 pop on empty ignored");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_wm_packing();
    t_thresholds();
    t_flush_priority();
    t_simultaneous();
    t_wrap_and_limits();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule